// File: doc/BRIEF.md
# Typed-Flit Wide Link Engines

This block holds a matched transmit engine and receive engine for a short, wide, synchronous channel between two switches. Both ends share one clock, so no synchronizer is needed. Each cycle the channel carries one 16-bit word, a 4-bit forward control group and a 4-bit reverse group. The flit equals the physical transfer unit, so one complete flit crosses per clock. Two forward control bits give the flit its type, and the reverse group returns buffer credits.

The transmit side accepts packet words from an upstream valid/ready source. The first word of each packet becomes a routing-tag flit. Later words become body flits, and the word flagged last becomes an end flit that still carries data. When there is no word or no credit, the transmitter fills the cycle with an idle flit. The receive side rebuilds packet boundaries into a small buffer and presents them downstream with head and last markers. It returns one credit pulse for each buffer slot it frees, and it flags and discards flits that break the framing rules. In a system, one instance's transmit wires connect to the receive wires of the instance across the link.

Top module: `flit_link`

## Requirements
- R1: The forward control group uses bits [1:0] for the flit type: 2'b00 idle, 2'b01 routing tag, 2'b10 packet body, 2'b11 end of packet. Bits [3:2] are always zero. A flit's type and its data word appear on `tx_ctrl`/`tx_data` in the cycle after the upstream handshake.
- R2: The first word accepted after reset, and the first word accepted after an end flit, goes out as a routing tag. The `in_last` flag is ignored on that word.
- R3: Each other accepted word goes out as an end flit when `in_last` is high and as a body flit otherwise.
- R4: In any cycle after a cycle with no handshake, the forward link carries an idle flit with zero data.
- R5: The transmitter starts with CREDITS (8) credits and spends one per non-idle flit. It gains one credit for each set bit of `tx_rev[1:0]`. `in_ready` is low exactly while the count is zero, so no more than CREDITS non-idle flits are ever unanswered.
- R6: The receiver delivers accepted tag, body and end flits downstream in arrival order. `out_head` marks a tag and `out_last` marks an end. It buffers up to DEPTH (8) flits.
- R7: Each downstream pop produces a one-cycle pulse on `rx_rev[0]` in the following cycle.
- R8: An idle flit that arrives between a tag and its end is ignored. It neither ends the packet nor reaches the output.
- R9: A body or end flit that arrives with no open packet is discarded. It sets `frame_err`, which stays high until reset, and its credit is returned as a one-cycle pulse on `rx_rev[1]` in the next cycle.
- R10: A tag flit that arrives while a packet is open is discarded, with the same `frame_err` and `rx_rev[1]` effects as in R9. The open packet continues.
- R11: During reset, `in_ready` is high, `tx_ctrl`, `tx_data` and `rx_rev` are zero, `out_valid` is low and `frame_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Transmitter holds a credit |
| in_data | input | 16 | Upstream word |
| in_last | input | 1 | Word closes its packet |
| tx_data | output | 16 | Forward link data |
| tx_ctrl | output | 4 | Forward link control (type in [1:0]) |
| tx_rev | input | 4 | Reverse credit lines from the far receiver |
| rx_data | input | 16 | Incoming link data |
| rx_ctrl | input | 4 | Incoming link control |
| rx_rev | output | 4 | Reverse credit lines to the far transmitter |
| out_valid | output | 1 | Buffered flit available |
| out_ready | input | 1 | Downstream takes the flit |
| out_data | output | 16 | Buffered flit data |
| out_head | output | 1 | Flit was a routing tag |
| out_last | output | 1 | Flit was an end of packet |
| frame_err | output | 1 | Sticky framing-violation flag |

## Verification
The in-line properties check the following on every cycle:
- the credit count stays within its bound;
- no non-idle flit leaves while the count is zero;
- the reserved control bits stay zero;
- the error flag never falls outside reset;
- the receive buffer is never written while full;
- each pop is followed by its credit pulse.

Only the bench scenarios can show the following:
- tag, body and end types land on the right words, including a last flag on a tag;
- the data order survives random backpressure;
- exactly eight flits leave before the transmitter stalls, and credits come back after draining;
- idles inside a packet are skipped;
- a stray body flit or a duplicate tag is discarded and produces its own credit pulse.

// File: rtl/flit_link.sv
module flit_link #(
  parameter int W       = 16,
  parameter int CREDITS = 8,
  parameter int DEPTH   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic [W-1:0] tx_data,
  output logic [3:0]   tx_ctrl,
  input  logic [3:0]   tx_rev,
  input  logic [W-1:0] rx_data,
  input  logic [3:0]   rx_ctrl,
  output logic [3:0]   rx_rev,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_head,
  output logic         out_last,
  output logic         frame_err
);

  localparam int CW   = $clog2(CREDITS + 1);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW   = $clog2(DEPTH + 1);
  localparam int EW   = W + 2;
  localparam logic [1:0] F_IDLE = 2'b00;
  localparam logic [1:0] F_TAG  = 2'b01;
  localparam logic [1:0] F_BODY = 2'b10;
  localparam logic [1:0] F_END  = 2'b11;

  // ---------------- transmit engine ----------------
  logic [CW-1:0] cred;
  logic          tx_head;
  logic [1:0]    tx_kind;
  logic [1:0]    ret;
  logic          tx_fire;

  assign in_ready = (cred != '0);
  assign tx_fire  = in_valid && in_ready;
  assign tx_kind  = tx_head ? F_TAG : (in_last ? F_END : F_BODY);
  assign ret      = {1'b0, tx_rev[0]} + {1'b0, tx_rev[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cred    <= CW'(CREDITS);
      tx_head <= 1'b1;
      tx_data <= '0;
      tx_ctrl <= '0;
    end else begin
      cred    <= cred - CW'(tx_fire) + CW'(ret);
      tx_ctrl <= {2'b00, tx_fire ? tx_kind : F_IDLE};
      tx_data <= tx_fire ? in_data : '0;
      if (tx_fire) tx_head <= (tx_kind == F_END);
    end
  end

  // R5
  // credit_zero_idle_chk
  credit_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cred == '0) |=> (tx_ctrl[1:0] == F_IDLE));
  // R5
  credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cred <= CW'(CREDITS));
  // R1
  ctrl_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ctrl[3:2] == 2'b00);

  // ---------------- receive engine ----------------
  logic [1:0]    rk;
  logic          is_tag, is_body, drop, wr, pop, open_pkt;
  logic [AW-1:0] wp, rp;
  logic [NW-1:0] cnt;
  logic [EW-1:0] mem [DEPTH];

  assign rk      = rx_ctrl[1:0];
  assign is_tag  = (rk == F_TAG);
  assign is_body = (rk == F_BODY) || (rk == F_END);
  assign drop    = (is_tag && open_pkt) || (is_body && !open_pkt);
  assign wr      = (is_tag || is_body) && !drop;
  assign pop     = out_valid && out_ready;

  assign out_valid = (cnt != '0);
  assign {out_head, out_last, out_data} = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= {is_tag, rk == F_END, rx_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      open_pkt  <= 1'b0;
      frame_err <= 1'b0;
      rx_rev    <= '0;
    end else begin
      if (wr)  wp <= nxt(wp);
      if (pop) rp <= nxt(rp);
      cnt <= cnt + NW'(wr) - NW'(pop);
      if (wr) open_pkt <= is_tag || (rk == F_BODY);
      frame_err <= frame_err | drop;
      rx_rev    <= {2'b00, drop, pop};
    end
  end

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (cnt < NW'(DEPTH)));
  // R7
  pop_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> rx_rev[0]);

endmodule

// File: tb/sim_flit_link.sv
module sim_flit_link;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [15:0] in_data = '0;
  logic [15:0] tx_data, rx_data, out_data;
  logic [3:0]  tx_ctrl, rx_ctrl, tx_rev, rx_rev;
  logic        in_ready, out_valid, out_head, out_last, frame_err;
  logic        inj = 1'b0;
  logic [15:0] inj_data = '0;
  logic [3:0]  inj_ctrl = '0;

  assign rx_data = inj ? inj_data : tx_data;
  assign rx_ctrl = inj ? inj_ctrl : tx_ctrl;
  assign tx_rev  = inj ? 4'b0 : rx_rev;

  flit_link u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .tx_data(tx_data), .tx_ctrl(tx_ctrl),
    .tx_rev(tx_rev), .rx_data(rx_data), .rx_ctrl(rx_ctrl), .rx_rev(rx_rev),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_head(out_head), .out_last(out_last), .frame_err(frame_err));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int nonidle = 0, resv_bad = 0, pops = 0, pulses = 0;
  bit hold = 1'b0, bp = 1'b0, tb_head = 1'b1;
  logic [17:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // link and output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_ctrl[1:0] != 2'b00) nonidle++;
      if (tx_ctrl[3:2] != 2'b00) resv_bad++;
      if (rx_rev[0]) pulses++;
      out_ready = hold ? 1'b0 : (bp ? 1'($urandom % 2) : 1'b1);
      if (out_valid && out_ready) begin
        pops++;
        if (exp_q.size() == 0)
          chk(1'b0, "R6 unexpected flit", {14'b0, out_head, out_last, out_data}, 0);
        else begin
          logic [17:0] e;
          e = exp_q.pop_front();
          chk({out_head, out_last, out_data} == e, "R6 delivered flit",
              {14'b0, out_head, out_last, out_data}, {14'b0, e});
        end
      end
    end
  end

  task automatic send_word(input logic [15:0] d, input logic l);
    bit f;
    logic [1:0] et;
    et = tb_head ? 2'b01 : (l ? 2'b11 : 2'b10);
    exp_q.push_back({tb_head, l && !tb_head, d});
    in_valid = 1'b1; in_data = d; in_last = l;
    do begin
      f = in_ready;
      @(posedge clk);
      @(negedge clk);
    end while (!f);
    chk(tx_ctrl[1:0] == et, tb_head ? "R2 tag type" : "R3 body/end type", tx_ctrl, et);
    chk(tx_data == d, "R1 flit data", tx_data, d);
    tb_head = !tb_head && l;
    in_valid = 1'b0;
  endtask

  task automatic send_pkt(input int n, input logic [15:0] base);
    for (int i = 0; i < n; i++) send_word(base + 16'(i), i == n - 1);
  endtask

  task automatic inj_flit(input logic [1:0] t, input logic [15:0] d);
    inj_ctrl = {2'b00, t}; inj_data = d;
    @(negedge clk);
    inj_ctrl = '0; inj_data = '0;
  endtask

  task automatic drain();
    for (int i = 0; i < 300; i++) begin
      if (exp_q.size() == 0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all flits delivered", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(in_ready == 1'b1, "R11 in_ready", in_ready, 1);
    chk(tx_ctrl == 4'b0 && tx_data == 16'b0, "R11 link idle", {tx_ctrl, tx_data}, 0);
    chk(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
    chk(frame_err == 1'b0, "R11 frame_err", frame_err, 0);
    chk(rx_rev == 4'b0, "R11 rx_rev", rx_rev, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R4 idle fill
    chk(tx_ctrl == 4'b0 && tx_data == 16'b0, "R4 idle flit", {tx_ctrl, tx_data}, 0);

    send_pkt(3, 16'h0100);
    send_pkt(2, 16'h0200);
    send_pkt(6, 16'h0300);
    drain();

    bp = 1'b1;
    send_pkt(4, 16'h1100);
    send_pkt(7, 16'h1200);
    send_pkt(2, 16'h1300);
    drain();
    bp = 1'b0;

    // R2: last flag on the tag word is ignored
    send_word(16'h0400, 1'b1);
    send_word(16'h0401, 1'b1);
    drain();

    // R5: credits stall transmitter at eight
    hold = 1'b1;
    @(negedge clk);
    nonidle = 0;
    fork send_pkt(10, 16'h0500); join_none
    repeat (30) @(negedge clk);
    chk(nonidle == 8, "R5 flits sent without credit return", nonidle, 8);
    chk(in_ready == 1'b0, "R5 in_ready low at zero credit", in_ready, 0);
    chk(out_valid == 1'b1, "R6 buffer holds flits", out_valid, 1);
    hold = 1'b0;
    wait fork;
    drain();
    // R7: returned credits allow eight more
    hold = 1'b1;
    @(negedge clk);
    nonidle = 0;
    fork send_pkt(9, 16'h0600); join_none
    repeat (30) @(negedge clk);
    chk(nonidle == 8, "R7 credits restored", nonidle, 8);
    hold = 1'b0;
    wait fork;
    drain();

    // R8: idles inside a packet
    inj = 1'b1;
    @(negedge clk);
    exp_q.push_back({2'b10, 16'h0700});
    exp_q.push_back({2'b00, 16'h0701});
    exp_q.push_back({2'b01, 16'h0702});
    inj_flit(2'b01, 16'h0700);
    inj_flit(2'b00, 16'h0000);
    inj_flit(2'b00, 16'h0000);
    inj_flit(2'b10, 16'h0701);
    inj_flit(2'b00, 16'h0000);
    inj_flit(2'b11, 16'h0702);
    drain();
    chk(frame_err == 1'b0, "R8 no framing error", frame_err, 0);

    // R9: body flit with no open packet
    inj_flit(2'b10, 16'h0800);
    chk(frame_err == 1'b1, "R9 frame_err set", frame_err, 1);
    chk(rx_rev[1] == 1'b1, "R9 drop credit pulse", rx_rev, 4'b0010);
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R9 flit discarded", out_valid, 0);
    chk(frame_err == 1'b1, "R9 frame_err sticky", frame_err, 1);
    inj_flit(2'b11, 16'h0801);
    chk(rx_rev[1] == 1'b1, "R9 stray end pulse", rx_rev, 4'b0010);

    // R10: duplicate tag inside packet
    exp_q.push_back({2'b10, 16'h0900});
    exp_q.push_back({2'b00, 16'h0902});
    exp_q.push_back({2'b01, 16'h0903});
    inj_flit(2'b01, 16'h0900);
    inj_flit(2'b01, 16'h0901);
    chk(rx_rev[1] == 1'b1, "R10 duplicate tag pulse", rx_rev, 4'b0010);
    inj_flit(2'b10, 16'h0902);
    inj_flit(2'b11, 16'h0903);
    drain();
    inj = 1'b0;
    repeat (4) @(negedge clk);

    chk(resv_bad == 0, "R1 reserved bits zero", resv_bad, 0);
    chk(pulses == pops, "R7 one pulse per pop", pulses, pops);
    finish_run();
  end
endmodule